// File: doc/BRIEF.md
# Polled Keyboard and Display Port

This peripheral sits on a processor bus and lets software move characters from a keyboard to a display by polling alone. It decodes four byte-wide registers inside its address window. Two are data registers, one per direction. The other two are status registers whose flags the hardware raises and drops as side effects of device events and data-register accesses. Software spins on a status bit, then touches the matching data register, and the access itself completes the handshake.

On the device side, a keyboard source presents a character together with a one-cycle valid strobe. The port keeps that character until the next one arrives. A display sink takes characters over a valid/ready handshake. The port holds one character at a time in each direction and never queues more. Bus reads and writes each complete in one cycle. Read data is combinational from the registered state and the current address.

Top module: `kbd_disp_port`

## Requirements
- R1: A cycle with `key_valid` high stores `key_char` in the keyboard data register (offset 0x00) and sets the key-ready flag, bit 1 of keyboard status (offset 0x04), from the next cycle on.
- R2: A read of keyboard data with no key arriving in the same cycle clears the key-ready flag for the next cycle. A read of keyboard status leaves the flag alone.
- R3: A key that arrives while key-ready is set and keyboard data is not being read in that cycle sets the lost-key bit (bit 0 of keyboard status) and replaces the stored character. A keyboard status read with no such key arriving clears the lost-key bit.
- R4: After reset, keyboard status reads 0x00, keyboard data reads 0x00 and display status (offset 0x14) reads 0x04, meaning the display is free.
- R5: A write to display data (offset 0x10) while the display-free flag (bit 2 of display status) is set clears that flag and raises `disp_valid` with the written byte on `disp_char` from the next cycle. Both hold unchanged until a cycle with `disp_ready` high.
- R6: After the sink takes a character (`disp_valid` and `disp_ready` both high at a clock edge), `disp_valid` falls at that edge. The display-free flag reads 1 starting one cycle after that.
- R7: A display data write while the display-free flag is clear is discarded, and so are writes to the keyboard registers and to display status.
- R8: Display data reads back the last character accepted for display. Status bits other than the named flags, unmapped offsets, and `bus_rdata` when no read is in progress all read as zero.
- R9: When a key arrives in the same cycle that keyboard data is read, the new character is stored, key-ready stays set, and the lost-key bit is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access to this peripheral in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Register offset within the window |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data, valid in the cycle of the read |
| key_valid | input | 1 | Keyboard character strobe |
| key_char | input | DATA_W (8) | Keyboard character |
| disp_valid | output | 1 | Character offered to display |
| disp_char | output | DATA_W (8) | Character to display |
| disp_ready | input | 1 | Display takes the offered character |

## Verification
The bench targets the cycles where a device event and a bus side effect collide. One case is a key landing on the same edge as a data read: a design that gave the read priority would drop key-ready and lose a character. Another is a key landing on a status read: a design that let the read win would hide the lost-key condition. A third is a display write made while the display is busy: a design that accepted it would corrupt the character held on `disp_char`. Finally, the bench checks that the display-free flag returns exactly one cycle after acceptance and not at the accepting edge, and it runs a long random mix against a behavioural model.

// File: rtl/kdp_pkg.sv
package kdp_pkg;
  // Status bit positions (software masks depend on them)
  localparam int KST_LOST_BIT  = 0;
  localparam int KST_READY_BIT = 1;
  localparam int DST_FREE_BIT  = 2;

  typedef enum logic [1:0] {
    DSP_IDLE = 2'd0,
    DSP_SEND = 2'd1,
    DSP_DONE = 2'd2
  } kdp_dsp_state_e;

  typedef struct packed {
    logic rd_kdata;
    logic rd_kstat;
    logic wr_ddata;
  } kdp_strobe_t;
endpackage

// File: rtl/kdp_rst_sync.sv
module kdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/kdp_kbd_chan.sv
module kdp_kbd_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_valid,
  input  logic [DATA_W-1:0] key_char,
  input  logic              rd_data,
  input  logic              rd_stat,
  output logic [DATA_W-1:0] kdata,
  output logic              kready,
  output logic              klost
);
  logic [DATA_W-1:0] data_q;
  logic              rdy_q, rdy_n;
  logic              lost_q, lost_n;
  logic              data_en;

  assign data_en = key_valid;

  always_comb begin
    rdy_n  = rdy_q;
    lost_n = lost_q;
    if (key_valid) begin
      rdy_n = 1'b1;
      if (rdy_q && !rd_data) lost_n = 1'b1;
      else if (rd_stat)      lost_n = 1'b0;
    end else begin
      if (rd_data) rdy_n  = 1'b0;
      if (rd_stat) lost_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= key_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_n;
      lost_q <= lost_n;
    end
  end

  assign kdata  = data_q;
  assign kready = rdy_q;
  assign klost  = lost_q;

  assert_key_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> (kready && kdata == $past(key_char)));
  assert_key_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |=> $stable(kdata));
  assert_read_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !key_valid) |=> !kready);
  assert_lost_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && kready && !rd_data) |=> klost);
  assert_lost_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !key_valid) |=> !klost);
  assert_race_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && rd_data && !klost) |=> (kready && !klost));
endmodule

// File: rtl/kdp_disp_chan.sv
module kdp_disp_chan
  import kdp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_data,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sink_ready,
  output logic              sink_valid,
  output logic [DATA_W-1:0] sink_char,
  output logic              free
);
  kdp_dsp_state_e    state_q, state_n;
  logic [DATA_W-1:0] char_q;
  logic              char_en;

  assign char_en = (state_q == DSP_IDLE) && wr_data;

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      DSP_IDLE: if (wr_data)    state_n = DSP_SEND;
      DSP_SEND: if (sink_ready) state_n = DSP_DONE;
      DSP_DONE:                 state_n = DSP_IDLE;
      default:                  state_n = DSP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DSP_IDLE;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       char_q <= '0;
    else if (char_en) char_q <= wdata;
  end

  assign sink_valid = (state_q == DSP_SEND);
  assign sink_char  = char_q;
  assign free       = (state_q == DSP_IDLE);

  assert_write_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && free) |=> (sink_valid && !free && sink_char == $past(wdata)));
  assert_offer_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid && !sink_ready) |=> (sink_valid && $stable(sink_char)));
  assert_accept_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid && sink_ready) |=> (!sink_valid && !free));
  assert_free_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sink_valid && sink_ready) |-> ##2 free);
  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !free) |=> $stable(sink_char));
  assert_free_xor_offer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(free && sink_valid));
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
  import kdp_pkg::*;
#(
  parameter int              DATA_W    = 8,
  parameter int              ADDR_W    = 5,
  parameter int              RST_STAGE = 2,
  parameter logic [ADDR_W-1:0] OFS_KDATA = 5'h00,
  parameter logic [ADDR_W-1:0] OFS_KSTAT = 5'h04,
  parameter logic [ADDR_W-1:0] OFS_DDATA = 5'h10,
  parameter logic [ADDR_W-1:0] OFS_DSTAT = 5'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              key_valid,
  input  logic [DATA_W-1:0] key_char,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_char,
  input  logic              disp_ready
);
  logic              rst_int_n;
  logic              bus_rd, bus_wr;
  kdp_strobe_t       strobe;
  logic [DATA_W-1:0] kdata, kstat, dstat;
  logic              kready, klost, dfree;

  kdp_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_int_n)
  );

  assign bus_rd = bus_sel && !bus_we;
  assign bus_wr = bus_sel &&  bus_we;

  always_comb begin
    strobe          = '0;
    strobe.rd_kdata = bus_rd && (bus_addr == OFS_KDATA);
    strobe.rd_kstat = bus_rd && (bus_addr == OFS_KSTAT);
    strobe.wr_ddata = bus_wr && (bus_addr == OFS_DDATA);
  end

  kdp_kbd_chan #(.DATA_W(DATA_W)) u_kbd (
    .clk(clk), .rst_n(rst_int_n),
    .key_valid(key_valid), .key_char(key_char),
    .rd_data(strobe.rd_kdata), .rd_stat(strobe.rd_kstat),
    .kdata(kdata), .kready(kready), .klost(klost)
  );

  kdp_disp_chan #(.DATA_W(DATA_W)) u_disp (
    .clk(clk), .rst_n(rst_int_n),
    .wr_data(strobe.wr_ddata), .wdata(bus_wdata),
    .sink_ready(disp_ready), .sink_valid(disp_valid),
    .sink_char(disp_char), .free(dfree)
  );

  always_comb begin
    kstat = '0;
    kstat[KST_READY_BIT] = kready;
    kstat[KST_LOST_BIT]  = klost;
    dstat = '0;
    dstat[DST_FREE_BIT]  = dfree;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_KDATA: bus_rdata = kdata;
        OFS_KSTAT: bus_rdata = kstat;
        OFS_DDATA: bus_rdata = disp_char;
        OFS_DSTAT: bus_rdata = dstat;
        default:   bus_rdata = '0;
      endcase
    end
  end

  assert_idle_bus_zero_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bus_rd |-> (bus_rdata == '0));
  assert_kbd_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && !key_valid) |=> $stable(kdata));
endmodule

// File: tb/kbd_disp_port_test.sv
module kbd_disp_port_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_we;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       key_valid;
  logic [7:0] key_char;
  logic       disp_valid;
  logic [7:0] disp_char;
  logic       disp_ready;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [7:0] m_kdata, m_dchar;
  bit         m_krdy, m_lost;
  int         m_phase; // 0 free, 1 offering, 2 returning

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_disp_port uut (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_valid(key_valid), .key_char(key_char),
    .disp_valid(disp_valid), .disp_char(disp_char), .disp_ready(disp_ready)
  );

  task automatic check8(input string tag, input string what,
                        input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata(bit sel, bit we, logic [4:0] a);
    if (!sel || we) return 8'h00;
    case (a)
      5'h00:   return m_kdata;
      5'h04:   return {6'b0, m_krdy, m_lost};
      5'h10:   return m_dchar;
      5'h14:   return (m_phase == 0) ? 8'h04 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  // One cycle: drive at negedge, compare, advance model at posedge.
  task automatic step(input bit sel, input bit we, input logic [4:0] a,
                      input logic [7:0] wd, input bit kv, input logic [7:0] kc,
                      input bit sr, input string tag);
    bit rd0, rd4, wr10;
    bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
    key_valid = kv; key_char = kc; disp_ready = sr;
    #1;
    check8(tag, "rdata", bus_rdata, exp_rdata(sel, we, a));
    check8("R5", "disp_valid", {7'b0, disp_valid}, {7'b0, m_phase == 1});
    if (m_phase == 1) check8("R5", "disp_char", disp_char, m_dchar);
    @(posedge clk);
    rd0  = sel && !we && a == 5'h00;
    rd4  = sel && !we && a == 5'h04;
    wr10 = sel && we && a == 5'h10;
    if (kv) begin
      if (m_krdy && !rd0) m_lost = 1;
      else if (rd4)       m_lost = 0;
      m_kdata = kc;
      m_krdy  = 1;
    end else begin
      if (rd0) m_krdy = 0;
      if (rd4) m_lost = 0;
    end
    case (m_phase)
      0: if (wr10) begin m_dchar = wd; m_phase = 1; end
      1: if (sr) m_phase = 2;
      default: m_phase = 0;
    endcase
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    step(1, 0, a, 8'h00, 0, 8'h00, 0, tag);
  endtask
  task automatic wr(input logic [4:0] a, input logic [7:0] d, input string tag);
    step(1, 1, a, d, 0, 8'h00, 0, tag);
  endtask
  task automatic key(input logic [7:0] c, input string tag);
    step(0, 0, 5'h00, 8'h00, 1, c, 0, tag);
  endtask
  task automatic idle(input bit sr, input string tag);
    step(0, 0, 5'h00, 8'h00, 0, 8'h00, sr, tag);
  endtask

  function automatic string tag_of(logic [4:0] a);
    case (a)
      5'h00:   return "R2";
      5'h04:   return "R3";
      5'h14:   return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_kdata = 0; m_dchar = 0; m_krdy = 0; m_lost = 0; m_phase = 0;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    key_valid = 0; key_char = 0; disp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) idle(0, "R4");

    // R4: reset state
    rd(5'h04, "R4"); rd(5'h00, "R4"); rd(5'h14, "R4");

    // R1 / R2: key delivery and clearing by data read
    key(8'h41, "R1");
    rd(5'h04, "R1");
    rd(5'h04, "R2");        // status read keeps ready
    rd(5'h00, "R1");
    rd(5'h04, "R2");

    // R3: lost key and clearing by status read
    key(8'h42, "R3"); key(8'h43, "R3");
    rd(5'h04, "R3");
    rd(5'h04, "R3");
    rd(5'h00, "R3");

    // R3: key arriving during status read with ready set
    key(8'h44, "R3");
    step(1, 0, 5'h04, 8'h00, 1, 8'h45, 0, "R3");
    rd(5'h04, "R3"); rd(5'h04, "R3"); rd(5'h00, "R3");

    // R9: key arriving during data read
    key(8'h46, "R9");
    step(1, 0, 5'h00, 8'h00, 1, 8'h47, 0, "R9");
    rd(5'h04, "R9"); rd(5'h00, "R9"); rd(5'h04, "R9");

    // R7: writes to keyboard registers and display status ignored
    key(8'h48, "R7");
    wr(5'h00, 8'hEE, "R7"); wr(5'h04, 8'hFF, "R7"); wr(5'h14, 8'h00, "R7");
    rd(5'h04, "R7"); rd(5'h00, "R7"); rd(5'h14, "R7");

    // R8: unmapped offsets
    rd(5'h08, "R8"); rd(5'h1C, "R8"); rd(5'h01, "R8");

    // R5 / R6 / R7: display handshake with stalls
    wr(5'h10, 8'h55, "R5");
    rd(5'h14, "R5");
    idle(0, "R5");
    wr(5'h10, 8'h66, "R7");  // busy: discarded
    rd(5'h10, "R7");
    idle(1, "R6");           // accepted here
    rd(5'h14, "R6");         // still clear one cycle
    rd(5'h14, "R6");         // free again
    rd(5'h10, "R8");

    // back-to-back with sink always ready; write during return cycle ignored
    wr(5'h10, 8'h77, "R5");
    step(1, 1, 5'h10, 8'h88, 0, 8'h00, 1, "R6");
    wr(5'h10, 8'h99, "R7");
    rd(5'h14, "R6"); rd(5'h10, "R7");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] a;
      bit s, w;
      case ($urandom_range(0, 5))
        0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h10; 3: a = 5'h14;
        4: a = 5'h08; default: a = 5'h10;
      endcase
      s = ($urandom_range(0, 2) != 0);
      w = ($urandom_range(0, 2) == 0);
      step(s, w, a, 8'($urandom), ($urandom_range(0, 3) == 0), 8'($urandom),
           ($urandom_range(0, 1) == 1), tag_of(a));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule